// File: doc/BRIEF.md
# Per-Channel Gamma Correction Table

This block applies gamma correction to pixels on their way to up to three display outputs. Each output channel owns three 256-entry tables of 8-bit values, one for red, one for green and one for blue. A pixel arrives with 24 bits of RGB and a channel number. Each of its three 8-bit components indexes that channel's table for the same colour, and the three results form the corrected pixel one clock later.

The tables are loaded through two write strobes. An address write sets a pointer into one flat table space and latches an auto-increment flag. A data write then stores one byte at the pointer. A driver usually points at the start of a channel, sets auto-increment, and streams 768 bytes: all red entries, then all green, then all blue.

Each channel has its own enable. A channel whose enable is clear passes pixels through unchanged, which is the same as an identity table. When no channel is enabled, the table storage counts as powered down. Its contents are lost and must be written again.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset, out_valid is 0 and out_rgb is 0. No table entry is loaded, and an unloaded entry reads as 0 when its channel has gamma enabled.
- R2: A cycle with addr_wr_en high loads the address pointer from addr_wr_val and the auto-increment flag from addr_wr_inc. A value of 2304 or more loads 0 instead.
- R3: A data_wr_en cycle stores data_wr_val at the entry the pointer selects. Address = channel*768 + component*256 + index, where component 0 is red, 1 is green and 2 is blue. With the auto-increment flag set, the pointer then advances by one.
- R4: With the auto-increment flag set, a data write at address 2303 moves the pointer to 0.
- R5: With the auto-increment flag clear, data writes leave the pointer unchanged, so successive writes overwrite the same entry.
- R6: Lookup latency is one cycle. out_valid in a cycle equals pix_valid in the previous cycle, and out_rgb holds its value while no pixel arrives.
- R7: When gamma_en[pix_chan] is 0, or pix_chan is 3, out_rgb equals pix_rgb one cycle later.
- R8: When gamma_en[pix_chan] is 1, out_rgb is {table[c][red][p[23:16]], table[c][green][p[15:8]], table[c][blue][p[7:0]]}, where red sits in bits 23:16 and blue in bits 7:0.
- R9: Any cycle in which all gamma_en bits are 0 erases every entry, so entries read as 0 until written again. A data write in such a cycle is discarded, but it still advances the pointer when auto-increment is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gamma_en | input | 3 | Per-channel gamma enable |
| addr_wr_en | input | 1 | Address pointer write strobe |
| addr_wr_val | input | 12 | New pointer value |
| addr_wr_inc | input | 1 | Auto-increment flag written with the pointer |
| data_wr_en | input | 1 | Table data write strobe |
| data_wr_val | input | 8 | Table entry value |
| pix_valid | input | 1 | Pixel present |
| pix_chan | input | 2 | Channel number of the pixel |
| pix_rgb | input | 24 | Input pixel, red in 23:16 |
| out_valid | output | 1 | Corrected pixel present |
| out_rgb | output | 24 | Corrected or bypassed pixel |

## Verification
The pointer properties assume that an address write and a data write never fall in the same cycle. The bench keeps the two strobes in separate cycles throughout. The bypass and latency properties accept any channel number, including the unused value 3, and the random lookups draw from all four values. Random gamma enables are always non-zero, so the tables are never erased by accident. Erasure is reached only through a directed all-zero enable step.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

    localparam int NUM_CHAN   = 3;
    localparam int NUM_COMP   = 3;
    localparam int COMP_W     = 8;
    localparam int ENTRIES    = 1 << COMP_W;
    localparam int CHAN_SPAN  = NUM_COMP * ENTRIES;
    localparam int TOTAL      = NUM_CHAN * CHAN_SPAN;
    localparam int ADDR_W     = $clog2(TOTAL);
    localparam int CHAN_W     = $clog2(NUM_CHAN);
    localparam int COMP_SEL_W = $clog2(NUM_COMP);
    localparam int PIX_W      = NUM_COMP * COMP_W;

    typedef logic [ADDR_W-1:0] lut_addr_t;
    typedef logic [COMP_W-1:0] comp_t;

    typedef enum logic [COMP_SEL_W-1:0] {
        COMP_RED   = 2'd0,
        COMP_GREEN = 2'd1,
        COMP_BLUE  = 2'd2
    } comp_sel_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        comp_sel_e         comp;
        comp_t             idx;
    } lut_loc_t;

    typedef struct packed {
        comp_t red;
        comp_t green;
        comp_t blue;
    } rgb_t;

    localparam lut_addr_t LAST_ADDR = lut_addr_t'(TOTAL - 1);

    // Split a flat table address into channel, colour and entry index.
    function automatic lut_loc_t decode_addr(input lut_addr_t a);
        lut_loc_t    loc;
        int unsigned flat;
        int unsigned rem;
        flat     = 32'(a);
        rem      = flat % CHAN_SPAN;
        loc.chan = CHAN_W'(flat / CHAN_SPAN);
        loc.comp = comp_sel_e'(COMP_SEL_W'(rem / ENTRIES));
        loc.idx  = comp_t'(rem % ENTRIES);
        return loc;
    endfunction

    function automatic lut_addr_t step_addr(input lut_addr_t a);
        return (a == LAST_ADDR) ? '0 : a + lut_addr_t'(1);
    endfunction

    function automatic lut_addr_t clamp_addr(input lut_addr_t a);
        return (32'(a) < TOTAL) ? a : '0;
    endfunction

    function automatic comp_t pick_comp(input rgb_t p, input int k);
        case (k)
            0:       return p.red;
            1:       return p.green;
            default: return p.blue;
        endcase
    endfunction

endpackage

// File: rtl/gamma_addr_ctrl.sv
module gamma_addr_ctrl
    import gamma_lut_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      addr_wr_en,
    input  lut_addr_t addr_wr_val,
    input  logic      addr_wr_inc,
    input  logic      data_wr_en,
    output lut_addr_t addr_q,
    output logic      inc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            inc_q  <= 1'b0;
        end else if (addr_wr_en) begin
            addr_q <= clamp_addr(addr_wr_val);
            inc_q  <= addr_wr_inc;
        end else if (data_wr_en && inc_q) begin
            addr_q <= step_addr(addr_q);
        end
    end

endmodule

// File: rtl/gamma_table_bank.sv
module gamma_table_bank #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  loaded;

    // Storage itself carries no reset; the loaded flags decide what reads back.
    always_ff @(posedge clk) begin
        if (wr_en && !clear) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            loaded <= '0;
        end else if (wr_en) begin
            loaded[wr_idx] <= 1'b1;
        end
    end

    assign rd_data = loaded[rd_idx] ? mem[rd_idx] : '0;

endmodule

// File: rtl/gamma_pixel_path.sv
module gamma_pixel_path #(
    parameter int NCH   = 3,
    parameter int NCOMP = 3,
    parameter int CW    = 8,
    parameter int SELW  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pix_valid,
    input  logic [SELW-1:0]         pix_chan,
    input  logic [NCOMP*CW-1:0]     pix_rgb,
    input  logic [NCH-1:0]          gamma_en,
    input  logic [NCH*NCOMP*CW-1:0] tbl_data,
    output logic                    out_valid,
    output logic [NCOMP*CW-1:0]     out_rgb
);

    localparam int PW     = NCOMP * CW;
    localparam int SEL_N  = 1 << SELW;

    logic [SEL_N-1:0] en_ext;
    logic [PW-1:0]    chan_data;
    logic [PW-1:0]    next_rgb;

    always_comb begin
        en_ext          = '0;
        en_ext[NCH-1:0] = gamma_en;
        chan_data       = '0;
        for (int c = 0; c < NCH; c++) begin
            if (pix_chan == SELW'(c)) begin
                chan_data = tbl_data[c*PW +: PW];
            end
        end
        next_rgb = en_ext[pix_chan] ? chan_data : pix_rgb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= pix_valid;
            if (pix_valid) begin
                out_rgb <= next_rgb;
            end
        end
    end

endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
    import gamma_lut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CHAN-1:0] gamma_en,
    input  logic              addr_wr_en,
    input  logic [ADDR_W-1:0] addr_wr_val,
    input  logic              addr_wr_inc,
    input  logic              data_wr_en,
    input  logic [COMP_W-1:0] data_wr_val,
    input  logic              pix_valid,
    input  logic [CHAN_W-1:0] pix_chan,
    input  logic [PIX_W-1:0]  pix_rgb,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_rgb
);

    lut_addr_t addr_q;
    logic      inc_q;
    lut_loc_t  wr_loc;
    logic      pwr_down;
    rgb_t      pix_s;
    logic [NUM_CHAN*PIX_W-1:0] tbl_data;

    assign wr_loc   = decode_addr(addr_q);
    assign pwr_down = ~|gamma_en;
    assign pix_s    = rgb_t'(pix_rgb);

    gamma_addr_ctrl u_addr (
        .clk         (clk),
        .rst         (rst),
        .addr_wr_en  (addr_wr_en),
        .addr_wr_val (addr_wr_val),
        .addr_wr_inc (addr_wr_inc),
        .data_wr_en  (data_wr_en),
        .addr_q      (addr_q),
        .inc_q       (inc_q)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
            localparam int SLOT = c * NUM_COMP + (NUM_COMP - 1 - k);
            logic  bank_we;
            comp_t bank_rd_idx;

            assign bank_we = data_wr_en
                          && (wr_loc.chan == CHAN_W'(c))
                          && (wr_loc.comp == comp_sel_e'(COMP_SEL_W'(k)));
            assign bank_rd_idx = pick_comp(pix_s, k);

            gamma_table_bank #(
                .IDX_W  (COMP_W),
                .DATA_W (COMP_W)
            ) u_bank (
                .clk     (clk),
                .rst     (rst),
                .clear   (pwr_down),
                .wr_en   (bank_we),
                .wr_idx  (wr_loc.idx),
                .wr_data (data_wr_val),
                .rd_idx  (bank_rd_idx),
                .rd_data (tbl_data[SLOT*COMP_W +: COMP_W])
            );
        end
    end

    gamma_pixel_path #(
        .NCH   (NUM_CHAN),
        .NCOMP (NUM_COMP),
        .CW    (COMP_W),
        .SELW  (CHAN_W)
    ) u_path (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix_chan  (pix_chan),
        .pix_rgb   (pix_rgb),
        .gamma_en  (gamma_en),
        .tbl_data  (tbl_data),
        .out_valid (out_valid),
        .out_rgb   (out_rgb)
    );

endmodule

// File: rtl/gamma_lut_checker.sv
module gamma_lut_checker
    import gamma_lut_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NUM_CHAN-1:0] gamma_en,
    input logic              addr_wr_en,
    input logic [ADDR_W-1:0] addr_wr_val,
    input logic              data_wr_en,
    input logic              inc_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic              pix_valid,
    input logic [CHAN_W-1:0] pix_chan,
    input logic [PIX_W-1:0]  pix_rgb,
    input logic              out_valid,
    input logic [PIX_W-1:0]  out_rgb
);

    logic [(1<<CHAN_W)-1:0] en_wide;
    logic                   bypass_now;

    always_comb begin
        en_wide                = '0;
        en_wide[NUM_CHAN-1:0]  = gamma_en;
        bypass_now             = ~en_wide[pix_chan];
    end

    a_r2_addr_load: assert property (@(posedge clk) disable iff (rst)
        addr_wr_en && (32'(addr_wr_val) < TOTAL) |=> addr_q == $past(addr_wr_val));

    a_r2_addr_clamp: assert property (@(posedge clk) disable iff (rst)
        addr_wr_en && (32'(addr_wr_val) >= TOTAL) |=> addr_q == '0);

    a_r3_autoinc: assert property (@(posedge clk) disable iff (rst)
        data_wr_en && !addr_wr_en && inc_q && (addr_q != LAST_ADDR)
        |=> addr_q == $past(addr_q) + lut_addr_t'(1));

    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        data_wr_en && !addr_wr_en && inc_q && (addr_q == LAST_ADDR) |=> addr_q == '0);

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        data_wr_en && !addr_wr_en && !inc_q |=> $stable(addr_q));

    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid);

    a_r6_idle: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !out_valid && $stable(out_rgb));

    a_r7_bypass: assert property (@(posedge clk) disable iff (rst)
        pix_valid && bypass_now |=> out_rgb == $past(pix_rgb));

endmodule

bind gamma_lut_top gamma_lut_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .gamma_en    (gamma_en),
    .addr_wr_en  (addr_wr_en),
    .addr_wr_val (addr_wr_val),
    .data_wr_en  (data_wr_en),
    .inc_q       (inc_q),
    .addr_q      (addr_q),
    .pix_valid   (pix_valid),
    .pix_chan    (pix_chan),
    .pix_rgb     (pix_rgb),
    .out_valid   (out_valid),
    .out_rgb     (out_rgb)
);

// File: tb/gamma_lut_top_bench.sv
module gamma_lut_top_bench;
    import gamma_lut_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  gamma_en = '0;
    logic        addr_wr_en = 1'b0;
    logic [ADDR_W-1:0] addr_wr_val = '0;
    logic        addr_wr_inc = 1'b0;
    logic        data_wr_en = 1'b0;
    logic [7:0]  data_wr_val = '0;
    logic        pix_valid = 1'b0;
    logic [1:0]  pix_chan = '0;
    logic [23:0] pix_rgb = '0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_mem [TOTAL];
    bit         m_vld [TOTAL];
    int         m_addr = 0;
    bit         m_inc = 0;

    always #2 clk = ~clk;

    gamma_lut_top u_gamma_lut_top (
        .clk         (clk),
        .rst         (rst),
        .gamma_en    (gamma_en),
        .addr_wr_en  (addr_wr_en),
        .addr_wr_val (addr_wr_val),
        .addr_wr_inc (addr_wr_inc),
        .data_wr_en  (data_wr_en),
        .data_wr_val (data_wr_val),
        .pix_valid   (pix_valid),
        .pix_chan    (pix_chan),
        .pix_rgb     (pix_rgb),
        .out_valid   (out_valid),
        .out_rgb     (out_rgb)
    );

    function automatic logic [23:0] expect_pix(input logic [2:0] en, input int ch,
                                               input logic [23:0] p);
        logic [23:0] r;
        if (ch >= 3) return p;
        if (!en[ch]) return p;
        r = '0;
        for (int k = 0; k < 3; k++) begin
            int a;
            a = ch * 768 + k * 256 + int'(p[(2-k)*8 +: 8]);
            r[(2-k)*8 +: 8] = m_vld[a] ? m_mem[a] : 8'h00;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_en(input logic [2:0] e);
        @(negedge clk);
        gamma_en = e;
        @(posedge clk);
        if (e == 3'b000) begin
            for (int i = 0; i < TOTAL; i++) m_vld[i] = 0;
        end
    endtask

    task automatic wr_addr(input int v, input bit inc);
        @(negedge clk);
        addr_wr_en  = 1'b1;
        addr_wr_val = ADDR_W'(v);
        addr_wr_inc = inc;
        @(posedge clk);
        m_addr = (v < TOTAL) ? v : 0;
        m_inc  = inc;
        @(negedge clk);
        addr_wr_en = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] d);
        @(negedge clk);
        data_wr_en  = 1'b1;
        data_wr_val = d;
        @(posedge clk);
        if (gamma_en != 3'b000) begin
            m_mem[m_addr] = d;
            m_vld[m_addr] = 1;
        end
        if (m_inc) m_addr = (m_addr == TOTAL - 1) ? 0 : m_addr + 1;
        @(negedge clk);
        data_wr_en = 1'b0;
    endtask

    task automatic lookup(input string tag, input int ch, input logic [23:0] p);
        logic [23:0] exp;
        @(negedge clk);
        pix_valid = 1'b1;
        pix_chan  = 2'(ch);
        pix_rgb   = p;
        exp       = expect_pix(gamma_en, ch, p);
        @(negedge clk);
        chk(tag, out_rgb, exp);
        chk({tag, " valid"}, {23'd0, out_valid}, 24'd1);
        pix_valid = 1'b0;
        pix_rgb   = ~p;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] held;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < TOTAL; i++) begin
            m_mem[i] = 8'h00;
            m_vld[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid reset", {23'd0, out_valid}, 24'd0);
        chk("R1 out_rgb reset", out_rgb, 24'd0);
        @(negedge clk);
        rst = 1'b0;

        set_en(3'b111);
        // R1: unloaded entries read zero
        lookup("R1 unloaded", 0, 24'h123456);

        // R6: idle cycle after a lookup
        held = out_rgb;
        @(negedge clk);
        chk("R6 idle valid", {23'd0, out_valid}, 24'd0);
        chk("R6 idle hold", out_rgb, held);

        // R3: stream the whole table space with auto-increment
        wr_addr(0, 1'b1);
        for (int i = 0; i < TOTAL; i++) wr_data(8'($urandom));
        lookup("R3 layout ch1", 1, 24'h102030);
        lookup("R3 layout ch2", 2, 24'hFF00A5);

        // R4: pointer wrapped to 0, next write lands on entry 0
        wr_data(8'h5A);
        lookup("R4 wrap", 0, 24'h000000);

        // R8 / R7: random lookups with random non-zero enables and channels
        for (int n = 0; n < 300; n++) begin
            set_en(3'($urandom_range(1, 7)));
            lookup("R8 random", int'($urandom_range(0, 3)), 24'($urandom));
        end

        // R7: explicit bypass on a disabled channel and on channel 3
        set_en(3'b001);
        lookup("R7 disabled chan", 2, 24'hABCDEF);
        lookup("R7 chan 3", 3, 24'h13579B);

        // R5: no auto-increment, repeated writes hit the same entry
        set_en(3'b111);
        wr_addr(2303, 1'b0);
        wr_data(8'h11);
        wr_data(8'h22);
        wr_data(8'h33);
        lookup("R5 last write", 2, 24'h0000FF);
        lookup("R5 neighbour", 2, 24'h0000FE);

        // R2: out-of-range pointer loads 0
        wr_addr(4000, 1'b1);
        wr_data(8'h3C);
        lookup("R2 clamp", 0, 24'h000000);

        // R9: power-down erases tables and discards writes
        set_en(3'b000);
        lookup("R7 bypass while off", 1, 24'h445566);
        wr_addr(5, 1'b1);
        wr_data(8'hAA);
        wr_data(8'hBB);
        set_en(3'b111);
        lookup("R9 erased ch0", 0, 24'h050607);
        lookup("R9 erased ch2", 2, 24'hFFFFFF);
        // pointer advanced during power-down: now at 7
        wr_data(8'h77);
        lookup("R9 reload", 0, 24'h070000);
        for (int n = 0; n < 20; n++) begin
            lookup("R9 random", int'($urandom_range(0, 2)), 24'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule